// File: doc/BRIEF.md
# Serial Receive Character Queue with Overrun Stage

This block is the receive side of one serial channel, placed between a character deserialiser and a CPU register interface. Each complete byte is handed in with a one-cycle write strobe. The block holds up to three bytes in arrival order. One further byte can wait in a holding stage behind the queue, so a fourth character is not lost while the CPU is slow to respond.

The CPU sees the oldest byte on the read data output and removes it with a one-cycle read strobe. When a slot frees, a waiting byte in the holding stage moves into the queue in the same cycle. A byte is lost only when a fifth one arrives while the holding stage is still occupied. The new byte then replaces the waiting one, and a sticky overrun flag is raised. Parity, framing and break conditions arrive as plain set strobes. The receiver starts disabled. An enable strobe turns it on, and a clear strobe resets it.

Top module: `rx_char_queue`

## Requirements
- R1: Up to DEPTH (3) bytes are held in arrival order, and rd_data_o shows the oldest while the receiver is enabled. full_o is high exactly when 3 bytes are held.
- R2: A byte written while 3 bytes are held goes into the holding stage. It raises no error and leaves ready and full high.
- R3: A byte written while the holding stage is occupied replaces the held byte and sets ovr_o. ovr_o is then cleared only by rst_ni.
- R4: rdy_o is high from the cycle after any accepted write, and low once a read has emptied the queue.
- R5: A read removes the oldest byte. If the holding stage is occupied, its byte enters the queue in the same cycle, so full_o stays high.
- R6: When a read and a write come in the same cycle, the read is done first and the write uses the freed slot. Nothing is lost and no overrun is raised.
- R7: Every read while enabled clears par_o and brk_o, even with an empty queue. A set strobe in the same cycle wins. ovr_o and frm_o are not affected by reads.
- R8: par_err_i, frm_err_i and brk_i strobes set par_o, frm_o and brk_o while the receiver is enabled.
- R9: clr_i disables the receiver, empties the queue and the holding stage, and keeps the error flags. It overrides ena_i, and every other input is ignored in that cycle. ena_i alone enables the receiver.
- R10: While the receiver is disabled, rd_data_o is 0. Reads, writes and error strobes have no effect.
- R11: stat_o bit layout: bit0 ready, bit1 full, bits 2 and 3 always 0, bit4 overrun, bit5 parity, bit6 framing, bit7 break.
- R12: After rst_ni the receiver is disabled, the queue is empty, all flags are 0 and stat_o is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ena_i | input | 1 | Enable receiver strobe |
| clr_i | input | 1 | Receiver reset strobe |
| wr_i | input | 1 | Received byte strobe |
| wr_data_i | input | DATA_W | Received byte |
| par_err_i | input | 1 | Parity error set strobe |
| frm_err_i | input | 1 | Framing error set strobe |
| brk_i | input | 1 | Break received set strobe |
| rd_i | input | 1 | CPU read (pop) strobe |
| rd_data_o | output | DATA_W | Oldest byte, 0 when empty or disabled |
| rx_en_o | output | 1 | Receiver enabled |
| rdy_o | output | 1 | At least one byte held |
| full_o | output | 1 | Queue holds 3 bytes |
| ovr_o | output | 1 | Overrun, sticky |
| par_o | output | 1 | Parity error |
| frm_o | output | 1 | Framing error, sticky |
| brk_o | output | 1 | Break received |
| stat_o | output | 8 | Status byte per R11 |

## Verification
The hardest case to reach is a same-cycle read and write while the queue is full and the holding stage is occupied. Here the held byte must move in and the new byte must take its place without raising an overrun. The stimulus reaches it by filling three slots, writing a fourth byte into the holding stage, and then strobing read and write together. The bench checks that the overrun flag stays low. It then drains the queue to confirm the byte order, which shows that nothing was lost or duplicated. The test of an actual overrun runs after this one, because the overrun flag can only be cleared by rst_ni.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int ST_RDY  = 0;
  localparam int ST_FULL = 1;
  localparam int ST_OVR  = 4;
  localparam int ST_PAR  = 5;
  localparam int ST_FRM  = 6;
  localparam int ST_BRK  = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
    logic ovr;
  } rxq_err_t;
endpackage

// File: rtl/rxq_ring.sv
module rxq_ring #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q, wr_ptr_q;
  logic [CNT_W-1:0]  cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            mem_q[g] <= '0;
      else if (!flush_i && push_i && wr_ptr_q == PTR_W'(g))   mem_q[g] <= push_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      rd_ptr_q <= '0;
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      cnt_q <= cnt_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              drain_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (flush_i) begin
      valid_o <= 1'b0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= load_data_i;
    end else if (drain_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rxq_err_t set_i,
  input  logic     rd_clr_i,
  output rxq_err_t flags_o
);
  rxq_err_t clr_mask;

  always_comb begin
    clr_mask     = '0;
    clr_mask.par = rd_clr_i;
    clr_mask.brk = rd_clr_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_o <= '0;
    else         flags_o <= (flags_o & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/rx_char_queue.sv
module rx_char_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ena_i,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              par_err_i,
  input  logic              frm_err_i,
  input  logic              brk_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_en_o,
  output logic              rdy_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              par_o,
  output logic              frm_o,
  output logic              brk_o,
  output logic [7:0]        stat_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              en_q;
  logic              act;
  logic              rd_act, pop, mv, push, push_new, to_hold, ovr_set;
  logic [CNT_W-1:0]  cnt, cnt_mid;
  logic [DATA_W-1:0] head, hold_data, push_data;
  logic              hold_v, hold_mid_v;
  rxq_err_t          err_set, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (clr_i) en_q <= 1'b0;
    else if (ena_i) en_q <= 1'b1;
  end

  assign act    = en_q && !clr_i;
  assign rd_act = act && rd_i;
  assign pop    = rd_act && (cnt != '0);
  // hold stage only occupied while queue is full, so pop + refill keeps it full
  assign mv         = pop && hold_v;
  assign hold_mid_v = hold_v && !mv;
  assign cnt_mid    = cnt - CNT_W'(pop) + CNT_W'(mv);
  assign push_new   = act && wr_i && (cnt_mid < CNT_W'(DEPTH));
  assign to_hold    = act && wr_i && !push_new;
  assign ovr_set    = to_hold && hold_mid_v;
  assign push       = mv || push_new;
  assign push_data  = mv ? hold_data : wr_data_i;

  rxq_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (clr_i),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (cnt)
  );

  rxq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (clr_i),
    .load_i      (to_hold),
    .load_data_i (wr_data_i),
    .drain_i     (mv),
    .valid_o     (hold_v),
    .data_o      (hold_data)
  );

  always_comb begin
    err_set     = '0;
    err_set.ovr = ovr_set;
    err_set.par = act && par_err_i;
    err_set.frm = act && frm_err_i;
    err_set.brk = act && brk_i;
  end

  rxq_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (err_set),
    .rd_clr_i (rd_act),
    .flags_o  (err_q)
  );

  assign rd_data_o = (en_q && cnt != '0) ? head : '0;
  assign rx_en_o   = en_q;
  assign rdy_o     = (cnt != '0);
  assign full_o    = (cnt == CNT_W'(DEPTH));
  assign ovr_o     = err_q.ovr;
  assign par_o     = err_q.par;
  assign frm_o     = err_q.frm;
  assign brk_o     = err_q.brk;

  always_comb begin
    stat_o          = '0;
    stat_o[ST_RDY]  = rdy_o;
    stat_o[ST_FULL] = full_o;
    stat_o[ST_OVR]  = ovr_o;
    stat_o[ST_PAR]  = par_o;
    stat_o[ST_FRM]  = frm_o;
    stat_o[ST_BRK]  = brk_o;
  end
endmodule

// File: rtl/rx_char_queue_chk.sv
module rx_char_queue_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ena_i,
  input logic              clr_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              par_err_i,
  input logic              frm_err_i,
  input logic              brk_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rx_en_o,
  input logic              rdy_o,
  input logic              full_o,
  input logic              ovr_o,
  input logic              par_o,
  input logic              frm_o,
  input logic              brk_o,
  input logic [7:0]        stat_o
);
  a_r1_full_has_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> rdy_o);
  a_r3_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovr_o |=> ovr_o);
  a_r4_rdy_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && wr_i && !clr_i) |=> rdy_o);
  a_r7_rd_clears_par: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && rd_i && !clr_i && !par_err_i) |=> !par_o);
  a_r8_frm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_o |=> frm_o);
  a_r9_clr_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!rx_en_o && !rdy_o && !full_o));
  a_r10_dis_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_o |-> (rd_data_o == '0));
  a_r10_dis_no_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rx_en_o && !rdy_o && !ena_i) |=> !rdy_o);
  a_r11_tx_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[3:2] == 2'b00);
endmodule

bind rx_char_queue rx_char_queue_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/rx_char_queue_tb.sv
`timescale 1ns/1ps
module rx_char_queue_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ena = 0, clr = 0, wr = 0, rd = 0, par = 0, frm = 0, brk = 0;
  logic [7:0] wd = '0;
  logic [7:0] rdata, stat;
  logic       en_o, rdy, full, ovr, par_o, frm_o, brk_o;
  int         n_chk = 0, n_fail = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  rx_char_queue u_dut (
    .clk_i(clk), .rst_ni(rst_n), .ena_i(ena), .clr_i(clr), .wr_i(wr),
    .wr_data_i(wd), .par_err_i(par), .frm_err_i(frm), .brk_i(brk), .rd_i(rd),
    .rd_data_o(rdata), .rx_en_o(en_o), .rdy_o(rdy), .full_o(full), .ovr_o(ovr),
    .par_o(par_o), .frm_o(frm_o), .brk_o(brk_o), .stat_o(stat)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
    ena = 0; clr = 0; wr = 0; rd = 0; par = 0; frm = 0; brk = 0;
  endtask

  task automatic put(input logic [7:0] d); wr = 1; wd = d; step(); endtask
  task automatic get; rd = 1; step(); endtask

  task automatic do_reset;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic t_reset;
    do_reset();
    chk("R12 stat", stat, 8'h00);
    chk("R12 en", en_o, 0);
    chk("R12 data", rdata, 0);
  endtask

  task automatic t_disabled;
    put(8'h55);
    par = 1; step();
    chk("R10 wr ignored", stat, 8'h00);
    chk("R10 data zero", rdata, 0);
  endtask

  task automatic t_fill_hold;
    ena = 1; step();
    chk("R9 enabled", en_o, 1);
    put(8'h11);
    chk("R4 rdy after wr", stat, 8'h01);
    chk("R1 head", rdata, 8'h11);
    put(8'h22); put(8'h33);
    chk("R1 R11 full", stat, 8'h03);
    put(8'h44);
    chk("R2 hold no err", stat, 8'h03);
    get();
    chk("R5 head", rdata, 8'h22);
    chk("R5 full kept", full, 1);
    get();
    chk("R1 order", rdata, 8'h33);
    chk("R1 not full", stat, 8'h01);
    get();
    chk("R5 held byte", rdata, 8'h44);
    get();
    chk("R4 rdy cleared", stat, 8'h00);
  endtask

  task automatic t_concurrent;
    wr = 1; rd = 1; wd = 8'hB0; step();
    chk("R6 empty rd+wr data", rdata, 8'hB0);
    chk("R6 empty rd+wr stat", stat, 8'h01);
    get();
    put(8'hA1); put(8'hA2); put(8'hA3);
    wr = 1; rd = 1; wd = 8'hA4; step();
    chk("R6 full rd+wr", stat, 8'h03);
    chk("R6 head", rdata, 8'hA2);
    put(8'hA5);
    wr = 1; rd = 1; wd = 8'hA6; step();
    chk("R6 hold rd+wr no ovr", stat, 8'h03);
    chk("R6 head2", rdata, 8'hA3);
    get(); chk("R6 seq A4", rdata, 8'hA4);
    chk("R5 refill full", full, 1);
    get(); chk("R6 seq A5", rdata, 8'hA5);
    get(); chk("R6 seq A6", rdata, 8'hA6);
    get(); chk("R6 drained", stat, 8'h00);
  endtask

  task automatic t_overrun;
    put(8'hC1); put(8'hC2); put(8'hC3); put(8'hC4); put(8'hC5);
    chk("R3 ovr set", stat, 8'h13);
    chk("R3 head", rdata, 8'hC1);
    get(); get(); chk("R3 order", rdata, 8'hC3);
    get(); chk("R3 replaced", rdata, 8'hC5);
    get(); chk("R3 sticky", stat, 8'h10);
  endtask

  task automatic t_flags;
    do_reset();
    chk("R12 ovr cleared", stat, 8'h00);
    ena = 1; step();
    par = 1; step(); chk("R8 par", stat, 8'h20);
    brk = 1; step(); chk("R8 brk", stat, 8'hA0);
    frm = 1; step(); chk("R8 frm", stat, 8'hE0);
    get(); chk("R7 rd clears par brk", stat, 8'h40);
    rd = 1; par = 1; step();
    chk("R7 set wins", stat, 8'h60);
  endtask

  task automatic t_clear;
    put(8'hD1); put(8'hD2); put(8'hD3); put(8'hD4);
    chk("R2 held before clr", stat, 8'h63);
    clr = 1; step();
    chk("R9 flushed flags kept", stat, 8'h60);
    chk("R9 disabled", en_o, 0);
    chk("R10 data zero", rdata, 0);
    put(8'hD5);
    chk("R10 wr ignored", stat, 8'h60);
    get();
    chk("R10 rd no effect", stat, 8'h60);
    brk = 1; step();
    chk("R10 strobe ignored", stat, 8'h60);
    ena = 1; clr = 1; step();
    chk("R9 clr beats ena", en_o, 0);
    ena = 1; step();
    put(8'hD6);
    chk("R9 only new byte", rdata, 8'hD6);
    chk("R9 one entry", stat, 8'h61);
    get();
    chk("R9 hold emptied", stat, 8'h40);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_fill_hold();
    t_concurrent();
    t_overrun();
    t_flags();
    t_clear();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule